// File: doc/BRIEF.md
# Debug Command Dispatcher

This block sits between a host serial link and a small embedded CPU with its program flash. The serial layer, which is not part of this block, hands over one pair per transfer: a 4-bit register select and a 4-bit data nibble. Through these pairs the host builds a 16-bit holding register and a 16-bit address register one nibble at a time. It can also set a 4-bit mode register.

Writing a nibble to the command select starts one of sixteen debug commands. The command codes are:

- **0000** write the holding register to the CPU port at address bits [3:0].
- **0001** write holding bits [7:0] to flash at address bits [11:0].
- **0010** read that CPU port into the holding register.
- **0011** read that flash byte into holding bits [7:0].
- **0100** read the accumulator into the holding register.
- **0101** read the flash byte at the program counter into holding bits [7:0].
- **0110** read the program counter into the holding register.
- **0111** halt.
- **1000** run.
- **1001** single step.
- **1010** clear the program counter.
- **1011** reset the modules and the scratch registers.
- **1100** no operation.
- **1101** erase the flash page at address bits [11:6].
- **1110** erase the current partition.
- **1111** select the auxiliary partition.

The dispatcher first checks the command against the CPU halt state. If it accepts the command, it issues a single-cycle request to the CPU control side or to the flash controller side. It then waits for that side's acknowledge and copies any returned data into the holding register. Port accesses may be made while the CPU runs. In that case a port access that the CPU makes in the same cycle takes precedence.

Top module: `dbg_cmd_dispatch`

## Requirements
- R1: A transfer with select 0 to 3 loads the matching holding-register nibble, where select 0 is bits [3:0] and select 3 is bits [15:12]. Selects 4 to 7 load the address-register nibbles in the same order. The other nibbles keep their values.
- R2: Select 9 loads the mode register. Selects 10 to 15 change none of the holding, address or mode registers and start no command.
- R3: Codes 0000, 0010, 0111 and 1100 are accepted at any time. Every other code is accepted only when `cpu_halted` is 1. A command refused because the CPU runs sets `cmd_err` one cycle after the write and issues no request. The next accepted command clears `cmd_err`.
- R4: After a CPU or flash command is accepted, `busy` is 1 from the next cycle until the edge that samples the matching acknowledge. A command write made while `busy` is 1 is ignored entirely.
- R5: CPU-side codes (all except 0001, 0011, 1100, 1101, 1110 and 1111) give a one-cycle `cpu_req` in the cycle after acceptance. During that cycle `cpu_op` carries the code, `cpu_port` carries address bits [3:0] and `cpu_wdata` carries the holding register.
- R6: For codes 0000 and 0010, `cpu_req` is held back while `cpu_port_busy` is 1. It is raised in the first cycle in which `cpu_port_busy` is 0.
- R7: Codes 0001, 0011, 1101 and 1110 give a one-cycle `flash_req` with `flash_op` equal to the code and `flash_wdata` equal to holding bits [7:0]. `flash_addr` carries address bits [11:0]; for code 1101, bits [5:0] are forced to zero.
- R8: At the acknowledge edge, codes 0010, 0100 and 0110 copy all 16 bits of `cpu_rdata` into the holding register. Code 0101 copies `cpu_rdata[7:0]` into bits [7:0], and code 0011 copies `flash_rdata` into bits [7:0]; in both cases the upper byte is kept. All other codes leave the holding register unchanged.
- R9: Accepting code 1111 sets `flash_aux` on the next cycle without becoming busy. `flash_aux` stays set until a halt command (0111) is accepted, which clears it on the next cycle.
- R10: Code 1100 is accepted, clears `cmd_err`, raises no request and never sets `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_valid | input | 1 | One select/nibble pair is present |
| ser_addr | input | 4 | Register select |
| ser_data | input | 4 | Nibble to load |
| cpu_halted | input | 1 | CPU is in the halted state |
| cpu_port_busy | input | 1 | CPU is using its ports this cycle |
| cpu_req | output | 1 | Single-cycle request to CPU control |
| cpu_op | output | 4 | Command code for CPU control |
| cpu_port | output | 4 | Port number |
| cpu_wdata | output | 16 | Port write data |
| cpu_ack | input | 1 | CPU control finished the request |
| cpu_rdata | input | 16 | CPU-side read data |
| flash_req | output | 1 | Single-cycle request to the flash controller |
| flash_op | output | 4 | Command code for the flash controller |
| flash_addr | output | 12 | Flash byte or page address |
| flash_wdata | output | 8 | Flash write byte |
| flash_aux | output | 1 | Auxiliary partition selected |
| flash_ack | input | 1 | Flash controller finished the request |
| flash_rdata | input | 8 | Flash read byte |
| hold_reg | output | 16 | Holding register |
| addr_reg | output | 16 | Address register |
| mode_reg | output | 4 | Mode register |
| busy | output | 1 | A command is outstanding |
| cmd_err | output | 1 | The last command was refused |

## Verification
Nibble loads, the error flag, the auxiliary select and the busy rise all appear one cycle after the transfer edge. The bench drives each transfer at a falling edge and samples on the next falling edge. A request is due combinationally in the first cycle after acceptance in which it is not held back, so the bench checks it in that cycle and again one cycle later to see it drop. Captured data and the fall of `busy` are due on the edge that samples the acknowledge, so the bench drops the acknowledge at the next falling edge and checks the holding register there.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    C_PORT_WR    = 4'd0,
    C_FL_WR      = 4'd1,
    C_PORT_RD    = 4'd2,
    C_FL_RD      = 4'd3,
    C_ACC_RD     = 4'd4,
    C_PCFL_RD    = 4'd5,
    C_PC_RD      = 4'd6,
    C_HALT       = 4'd7,
    C_RUN        = 4'd8,
    C_STEP       = 4'd9,
    C_PC_CLR     = 4'd10,
    C_REG_CLR    = 4'd11,
    C_NOP        = 4'd12,
    C_PAGE_ERASE = 4'd13,
    C_PART_ERASE = 4'd14,
    C_AUX_SEL    = 4'd15
  } dbg_cmd_e;

  typedef enum logic [1:0] {TGT_LOCAL, TGT_CPU, TGT_FLASH} dbg_tgt_e;
  typedef enum logic [1:0] {CAP_NONE, CAP_CPU16, CAP_CPU8, CAP_FL8} dbg_cap_e;

  // Commands that may proceed while the CPU executes.
  function automatic logic runs_while_active(input logic [3:0] c);
    return (c == C_PORT_WR) || (c == C_PORT_RD) || (c == C_HALT) || (c == C_NOP);
  endfunction

  function automatic logic is_port_cmd(input logic [3:0] c);
    return (c == C_PORT_WR) || (c == C_PORT_RD);
  endfunction

  function automatic dbg_tgt_e target_of(input logic [3:0] c);
    case (c)
      C_FL_WR, C_FL_RD, C_PAGE_ERASE, C_PART_ERASE: return TGT_FLASH;
      C_NOP, C_AUX_SEL:                             return TGT_LOCAL;
      default:                                      return TGT_CPU;
    endcase
  endfunction

  function automatic dbg_cap_e capture_of(input logic [3:0] c);
    case (c)
      C_PORT_RD, C_ACC_RD, C_PC_RD: return CAP_CPU16;
      C_PCFL_RD:                    return CAP_CPU8;
      C_FL_RD:                      return CAP_FL8;
      default:                      return CAP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbg_nibble_regs.sv
module dbg_nibble_regs
  import dbg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NIB_W-1:0]  wr_sel,
  input  logic [NIB_W-1:0]  wr_nib,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_mask,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] hold_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [NIB_W-1:0]  mode_q
);
  localparam int DATA_NIBS = DATA_W / NIB_W;
  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int MODE_SEL  = DATA_NIBS + ADDR_NIBS + 1;

  // One lane per holding nibble; returned data overrides a host write.
  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_hold
    logic [NIB_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (cap_en && (|cap_mask[g*NIB_W +: NIB_W]))
        lane_q <= cap_data[g*NIB_W +: NIB_W];
      else if (wr_en && (wr_sel == NIB_W'(g)))
        lane_q <= wr_nib;
    end
    assign hold_q[g*NIB_W +: NIB_W] = lane_q;
  end

  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_addr
    logic [NIB_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (wr_en && (wr_sel == NIB_W'(DATA_NIBS + g)))
        lane_q <= wr_nib;
    end
    assign addr_q[g*NIB_W +: NIB_W] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_en && (wr_sel == NIB_W'(MODE_SEL)))
      mode_q <= wr_nib;
  end
endmodule

// File: rtl/dbg_cmd_fsm.sv
module dbg_cmd_fsm
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [NIB_W-1:0] cmd_code,
  input  logic             cpu_halted,
  input  logic             cpu_port_busy,
  input  logic             cpu_ack,
  input  logic             flash_ack,
  output logic             busy,
  output logic             cmd_err,
  output logic             aux_sel,
  output logic             cpu_req,
  output logic             flash_req,
  output logic [NIB_W-1:0] cur_cmd,
  output logic             ev_accept,
  output logic             ev_reject,
  output logic             cap_en,
  output dbg_cap_e         cap_kind
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;
  state_e   state_q;
  dbg_tgt_e cur_tgt;
  logic     cmd_take, issue_go, done;

  assign cmd_take  = cmd_wr && (state_q == S_IDLE);
  assign ev_accept = cmd_take && (cpu_halted || runs_while_active(cmd_code));
  assign ev_reject = cmd_take && !ev_accept;

  assign cur_tgt  = target_of(cur_cmd);
  // The CPU keeps priority on its ports: a debug port access waits.
  assign issue_go = (state_q == S_ISSUE) && !(is_port_cmd(cur_cmd) && cpu_port_busy);
  assign cpu_req  = issue_go && (cur_tgt == TGT_CPU);
  assign flash_req = issue_go && (cur_tgt == TGT_FLASH);
  assign done     = (state_q == S_WAIT) &&
                    ((cur_tgt == TGT_CPU) ? cpu_ack : flash_ack);
  assign cap_en   = done;
  assign cap_kind = capture_of(cur_cmd);
  assign busy     = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_cmd <= '0;
      cmd_err <= 1'b0;
      aux_sel <= 1'b0;
    end else begin
      if (ev_accept) begin
        cur_cmd <= cmd_code;
        cmd_err <= 1'b0;
        if (target_of(cmd_code) != TGT_LOCAL) state_q <= S_ISSUE;
        if (cmd_code == C_HALT)         aux_sel <= 1'b0;
        else if (cmd_code == C_AUX_SEL) aux_sel <= 1'b1;
      end else if (ev_reject) begin
        cmd_err <= 1'b1;
      end
      if (issue_go) state_q <= S_WAIT;
      if (done)     state_q <= S_IDLE;
    end
  end
endmodule

// File: rtl/dbg_cmd_dispatch.sv
module dbg_cmd_dispatch
  import dbg_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int PORT_W   = 4,
  parameter int FL_AW    = 12,
  parameter int FL_DW    = 8,
  parameter int PAGE_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_valid,
  input  logic [NIB_W-1:0]  ser_addr,
  input  logic [NIB_W-1:0]  ser_data,
  input  logic              cpu_halted,
  input  logic              cpu_port_busy,
  output logic              cpu_req,
  output logic [NIB_W-1:0]  cpu_op,
  output logic [PORT_W-1:0] cpu_port,
  output logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_ack,
  input  logic [DATA_W-1:0] cpu_rdata,
  output logic              flash_req,
  output logic [NIB_W-1:0]  flash_op,
  output logic [FL_AW-1:0]  flash_addr,
  output logic [FL_DW-1:0]  flash_wdata,
  output logic              flash_aux,
  input  logic              flash_ack,
  input  logic [FL_DW-1:0]  flash_rdata,
  output logic [DATA_W-1:0] hold_reg,
  output logic [ADDR_W-1:0] addr_reg,
  output logic [NIB_W-1:0]  mode_reg,
  output logic              busy,
  output logic              cmd_err
);
  localparam int CMD_SEL = DATA_W / NIB_W + ADDR_W / NIB_W;
  localparam logic [FL_AW-1:0] PAGE_MASK = {FL_AW{1'b1}} << PAGE_LSB;

  logic              cmd_wr, ev_accept, ev_reject, cap_en;
  logic [NIB_W-1:0]  cur_cmd;
  dbg_cap_e          cap_kind;
  logic [DATA_W-1:0] cap_mask, cap_data;

  assign cmd_wr = ser_valid && (ser_addr == NIB_W'(CMD_SEL));

  dbg_nibble_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ser_valid), .wr_sel(ser_addr), .wr_nib(ser_data),
    .cap_en(cap_en), .cap_mask(cap_mask), .cap_data(cap_data),
    .hold_q(hold_reg), .addr_q(addr_reg), .mode_q(mode_reg)
  );

  dbg_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_code(ser_data),
    .cpu_halted(cpu_halted), .cpu_port_busy(cpu_port_busy),
    .cpu_ack(cpu_ack), .flash_ack(flash_ack),
    .busy(busy), .cmd_err(cmd_err), .aux_sel(flash_aux),
    .cpu_req(cpu_req), .flash_req(flash_req), .cur_cmd(cur_cmd),
    .ev_accept(ev_accept), .ev_reject(ev_reject),
    .cap_en(cap_en), .cap_kind(cap_kind)
  );

  // Returned data lanes: full word from the CPU, or the low byte only.
  always_comb begin
    cap_mask = '0;
    cap_data = '0;
    case (cap_kind)
      CAP_CPU16: begin cap_mask = '1; cap_data = cpu_rdata; end
      CAP_CPU8:  begin cap_mask[FL_DW-1:0] = '1; cap_data[FL_DW-1:0] = cpu_rdata[FL_DW-1:0]; end
      CAP_FL8:   begin cap_mask[FL_DW-1:0] = '1; cap_data[FL_DW-1:0] = flash_rdata; end
      default:   ;
    endcase
  end

  assign cpu_op      = cur_cmd;
  assign cpu_port    = addr_reg[PORT_W-1:0];
  assign cpu_wdata   = hold_reg;
  assign flash_op    = cur_cmd;
  assign flash_wdata = hold_reg[FL_DW-1:0];
  assign flash_addr  = (cur_cmd == C_PAGE_ERASE) ? (addr_reg[FL_AW-1:0] & PAGE_MASK)
                                                 : addr_reg[FL_AW-1:0];
endmodule

// File: rtl/dbg_cmd_dispatch_chk.sv
module dbg_cmd_dispatch_chk #(
  parameter int CMD_SEL = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ser_valid,
  input logic [3:0] ser_addr,
  input logic [3:0] ser_data,
  input logic       cpu_halted,
  input logic       cpu_port_busy,
  input logic       cpu_req,
  input logic [3:0] cpu_op,
  input logic       flash_req,
  input logic       cpu_ack,
  input logic       flash_ack,
  input logic       busy,
  input logic       cmd_err,
  input logic       flash_aux,
  input logic       ev_accept,
  input logic [3:0] cur_cmd
);
  logic cmd_wr;
  assign cmd_wr = ser_valid && (ser_addr == 4'(CMD_SEL));

  p_refuse_only_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> $past(cmd_wr && !cpu_halted));

  p_accept_clears_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !cmd_err);

  p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(cur_cmd) && $stable(cmd_err)));

  p_busy_ends_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cpu_ack || flash_ack));

  p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && flash_req));

  p_req_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req || flash_req) |=> !(cpu_req || flash_req));

  p_port_yields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && (cpu_op == 4'd0 || cpu_op == 4'd2)) |-> !cpu_port_busy);

  p_halt_drops_aux_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ser_data == 4'd7) |=> !flash_aux);

  p_nop_stays_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ser_data == 4'd12) |=> !busy);
endmodule

bind dbg_cmd_dispatch dbg_cmd_dispatch_chk #(.CMD_SEL(CMD_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_addr(ser_addr),
  .ser_data(ser_data), .cpu_halted(cpu_halted), .cpu_port_busy(cpu_port_busy),
  .cpu_req(cpu_req), .cpu_op(cpu_op), .flash_req(flash_req),
  .cpu_ack(cpu_ack), .flash_ack(flash_ack), .busy(busy), .cmd_err(cmd_err),
  .flash_aux(flash_aux), .ev_accept(ev_accept), .cur_cmd(cur_cmd)
);

// File: tb/test_dbg_cmd_dispatch.sv
module test_dbg_cmd_dispatch;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ser_valid = 1'b0;
  logic [3:0]  ser_addr = '0, ser_data = '0;
  logic        cpu_halted = 1'b1, cpu_port_busy = 1'b0;
  logic        cpu_req, flash_req, flash_aux, busy, cmd_err;
  logic [3:0]  cpu_op, cpu_port, flash_op, mode_reg;
  logic [15:0] cpu_wdata, hold_reg, addr_reg;
  logic        cpu_ack = 1'b0, flash_ack = 1'b0;
  logic [15:0] cpu_rdata = '0;
  logic [11:0] flash_addr;
  logic [7:0]  flash_wdata, flash_rdata = '0;

  int total = 0, bad = 0;
  logic finished = 1'b0;

  logic [15:0] m_hold = '0, m_addr = '0;
  logic [3:0]  m_mode = '0;
  logic        m_err = 1'b0, m_aux = 1'b0;

  always #5 clk = ~clk;

  dbg_cmd_dispatch i_dbg_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_addr(ser_addr),
    .ser_data(ser_data), .cpu_halted(cpu_halted), .cpu_port_busy(cpu_port_busy),
    .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_port(cpu_port), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .flash_req(flash_req),
    .flash_op(flash_op), .flash_addr(flash_addr), .flash_wdata(flash_wdata),
    .flash_aux(flash_aux), .flash_ack(flash_ack), .flash_rdata(flash_rdata),
    .hold_reg(hold_reg), .addr_reg(addr_reg), .mode_reg(mode_reg),
    .busy(busy), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench view of the command set.
  function automatic logic any_time(input logic [3:0] c);
    return c == 4'd0 || c == 4'd2 || c == 4'd7 || c == 4'd12;
  endfunction
  function automatic int dest(input logic [3:0] c); // 0 local, 1 cpu, 2 flash
    if (c == 4'd12 || c == 4'd15) return 0;
    if (c == 4'd1 || c == 4'd3 || c == 4'd13 || c == 4'd14) return 2;
    return 1;
  endfunction

  task automatic chk_regs(input string tag);
    chk({tag, " hold"}, 32'(hold_reg), 32'(m_hold));
    chk({tag, " addr"}, 32'(addr_reg), 32'(m_addr));
    chk({tag, " mode"}, 32'(mode_reg), 32'(m_mode));
  endtask

  task automatic nib(input logic [3:0] a, input logic [3:0] d);
    ser_valid = 1'b1; ser_addr = a; ser_data = d;
    @(negedge clk);
    ser_valid = 1'b0;
    if (a < 4)       m_hold[a*4 +: 4] = d;
    else if (a < 8)  m_addr[(a-4)*4 +: 4] = d;
    else if (a == 9) m_mode = d;
  endtask

  task automatic run_cmd(input logic [3:0] code, input logic halted, input int pb,
                         input int dly, input logic [15:0] rd, input logic intrude);
    logic acc;
    int   t;
    acc = halted || any_time(code);
    t   = dest(code);
    cpu_halted = halted;
    cpu_port_busy = (pb > 0) && (code == 4'd0 || code == 4'd2);
    ser_valid = 1'b1; ser_addr = 4'd8; ser_data = code;
    @(negedge clk);
    ser_valid = 1'b0;
    if (!acc) begin
      m_err = 1'b1;
      chk("R3 refused err", 32'(cmd_err), 32'd1);
      chk("R3 refused no req", {cpu_req, flash_req, busy}, 32'd0);
      cpu_port_busy = 1'b0;
      return;
    end
    m_err = 1'b0;
    if (code == 4'd7) m_aux = 1'b0;
    if (code == 4'd15) m_aux = 1'b1;
    chk("R3 accepted err clear", 32'(cmd_err), 32'd0);
    if (t == 0) begin
      chk("R10 local no busy/req", {cpu_req, flash_req, busy}, 32'd0);
      chk("R9 aux", 32'(flash_aux), 32'(m_aux));
      return;
    end
    chk("R4 busy after accept", 32'(busy), 32'd1);
    if (cpu_port_busy) begin
      for (int i = 0; i < pb; i++) begin
        chk("R6 port req held", 32'(cpu_req), 32'd0);
        @(negedge clk);
      end
      cpu_port_busy = 1'b0;
      #1;
    end
    if (t == 1) begin
      chk("R5 cpu_req", {cpu_req, flash_req}, 32'b10);
      chk("R5 cpu_op", 32'(cpu_op), 32'(code));
      chk("R5 cpu_port", 32'(cpu_port), 32'(m_addr[3:0]));
      chk("R5 cpu_wdata", 32'(cpu_wdata), 32'(m_hold));
    end else begin
      chk("R7 flash_req", {cpu_req, flash_req}, 32'b01);
      chk("R7 flash_op", 32'(flash_op), 32'(code));
      chk("R7 flash_addr", 32'(flash_addr),
          32'((code == 4'd13) ? {m_addr[11:6], 6'b0} : m_addr[11:0]));
      chk("R7 flash_wdata", 32'(flash_wdata), 32'(m_hold[7:0]));
      chk("R9 flash_aux", 32'(flash_aux), 32'(m_aux));
    end
    @(negedge clk);
    chk("R5 req one cycle", {cpu_req, flash_req}, 32'd0);
    chk("R4 busy waiting", 32'(busy), 32'd1);
    if (intrude) begin
      // A command that would be refused and flag an error, sent while busy.
      cpu_halted = 1'b0;
      ser_valid = 1'b1; ser_addr = 4'd8; ser_data = 4'd1;
      @(negedge clk);
      ser_valid = 1'b0;
      chk("R4 write while busy ignored err", 32'(cmd_err), 32'(m_err));
      chk("R4 write while busy no req", {cpu_req, flash_req, busy}, 32'b001);
      cpu_halted = halted;
    end
    repeat (dly) @(negedge clk);
    cpu_rdata = rd;
    flash_rdata = rd[15:8] ^ 8'h5A;
    if (t == 1) cpu_ack = 1'b1; else flash_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0; flash_ack = 1'b0;
    case (code)
      4'd2, 4'd4, 4'd6: m_hold = rd;
      4'd5:             m_hold[7:0] = rd[7:0];
      4'd3:             m_hold[7:0] = rd[15:8] ^ 8'h5A;
      default: ;
    endcase
    chk("R4 busy drops on ack", 32'(busy), 32'd0);
    chk("R8 capture", 32'(hold_reg), 32'(m_hold));
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_regs("R1 reset");
    chk("R3 reset err", 32'(cmd_err), 32'd0);
    chk("R4 reset busy", {busy, cpu_req, flash_req, flash_aux}, 32'd0);

    // R1: nibble order in both registers
    for (int i = 0; i < 8; i++) nib(4'(i), 4'(i + 1));
    chk_regs("R1 nibble load");
    chk("R1 hold order", 32'(hold_reg), 32'h4321);
    chk("R1 addr order", 32'(addr_reg), 32'h8765);
    // R2: mode and unused selects
    nib(4'd9, 4'hC);
    for (int i = 10; i < 16; i++) nib(4'(i), 4'hF);
    chk_regs("R2 unused selects");
    chk("R2 no command", {busy, cmd_err}, 32'd0);

    // Directed commands
    run_cmd(4'd12, 1'b0, 0, 0, '0, 1'b0);       // R10 nop while running
    run_cmd(4'd4, 1'b0, 0, 0, '0, 1'b0);        // R3 refused
    run_cmd(4'd12, 1'b0, 0, 0, '0, 1'b0);       // R3/R10 nop clears err
    run_cmd(4'd2, 1'b0, 3, 1, 16'hBEEF, 1'b0);  // R6 port read while CPU uses ports
    run_cmd(4'd0, 1'b0, 1, 0, '0, 1'b1);        // R6 + R4 intrusion
    run_cmd(4'd15, 1'b1, 0, 0, '0, 1'b0);       // R9 aux on
    run_cmd(4'd13, 1'b1, 0, 2, '0, 1'b0);       // R7 page erase, aux visible
    run_cmd(4'd3, 1'b1, 0, 0, 16'h7700, 1'b0);  // R8 flash byte
    run_cmd(4'd5, 1'b1, 0, 0, 16'h1234, 1'b0);  // R8 byte from pc
    run_cmd(4'd7, 1'b1, 0, 0, '0, 1'b0);        // R9 halt clears aux
    chk("R9 aux cleared by halt", 32'(flash_aux), 32'd0);

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      if (($urandom % 10) < 6) begin
        logic [3:0] a;
        a = 4'($urandom % 16);
        if (a == 4'd8) a = 4'd9;
        nib(a, 4'($urandom));
        chk_regs("R1/R2 random load");
      end else begin
        run_cmd(4'($urandom), 1'($urandom % 3 != 0), int'($urandom % 3),
                int'($urandom % 4), 16'($urandom), 1'($urandom % 5 == 0));
      end
      chk("R3 err model", 32'(cmd_err), 32'(m_err));
      chk("R9 aux model", 32'(flash_aux), 32'(m_aux));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule